// File: doc/BRIEF.md
# UART Interrupt Identification Unit

This block collects the interrupt conditions of a 16550-style UART and turns them into one active-high interrupt line and an 8-bit identification code. The code names the single highest-priority source that is both pending and enabled. It takes the following inputs:

- four enable bits;
- error events from the receiver;
- the receive FIFO fill count and a 2-bit trigger selection;
- a character-timeout event, produced outside the block;
- the transmit FIFO empty flag;
- modem-line change events;
- one-cycle strobes for the register accesses that clear sources.

Line status, timeout, modem status and transmitter-empty are held in sticky pending bits inside the block. Each one is cleared by its own access side effect. Receive-data-available is a live comparison and has no state. The identification code is combinational, so the code presented in the cycle of a read strobe is the code that read returns. A read-to-clear therefore acts on the source that was actually reported.

Top module: `uart_irq_id`

## Requirements
- R1: After reset `irq_o` is 0 and `iid_o` is 8'hC1.
- R2: `irq_o` is 1 exactly when some enabled source is pending, and `iid_o[0]` is then 0. With nothing enabled and pending, `iid_o[0]` is 1 and `iid_o[3:1]` is 000.
- R3: `iid_o[3:1]` reports the highest enabled pending source. The sources, from highest to lowest priority, with their codes:
  - line status: 011
  - receive data available: 010
  - character timeout: 110
  - transmitter empty: 001
  - modem status: 000
- R4: Receive data available is active while `rx_cnt_i` is at least the trigger level, and inactive as soon as the count is below it. The trigger selection maps 00 to 1, 01 to 4, 10 to 8 and 11 to 14. It is gated by `en_i[0]`.
- R5: A pulse on any bit of `line_err_i` sets the line status source in the next cycle. A `lsr_rd_i` strobe clears it. If a new error arrives in the same cycle as the read, the source stays set. It is gated by `en_i[2]`.
- R6: A `rx_timeout_i` pulse sets the timeout source, and a `rbr_rd_i` strobe clears it. It is gated by `en_i[0]`.
- R7: The transmitter-empty source is set only by a 0-to-1 transition of `tx_empty_i` while `en_i[1]` is 1. A transition seen while `en_i[1]` is 0 leaves nothing pending. It is reported under `en_i[1]`.
- R8: The transmitter-empty source is cleared in two cases: by `thr_wr_i`, or by `iir_rd_i` in a cycle where `iid_o[3:1]` is 001. An `iir_rd_i` while another code is reported leaves it pending.
- R9: A pulse on any bit of `modem_delta_i` sets the modem status source, and `msr_rd_i` clears it. It is gated by `en_i[3]`.
- R10: A pending line status, timeout or modem status source whose enable is 0 affects neither output. Setting the enable later reports it at once, with no clock edge.
- R11: `iid_o[7:6]` is always 11 and `iid_o[5:4]` is always 00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| en_i | input | 4 | Source enables: 0 rx data/timeout, 1 tx empty, 2 line status, 3 modem status |
| line_err_i | input | 4 | Receiver error events (overrun, parity, framing, break) |
| rx_cnt_i | input | CNT_W | Receive FIFO fill count |
| trig_sel_i | input | 2 | Receive trigger level selection |
| rx_timeout_i | input | 1 | Character timeout event |
| tx_empty_i | input | 1 | Transmit FIFO empty flag |
| modem_delta_i | input | 4 | Modem line change events |
| iir_rd_i | input | 1 | Identification register read strobe |
| lsr_rd_i | input | 1 | Line status register read strobe |
| msr_rd_i | input | 1 | Modem status register read strobe |
| rbr_rd_i | input | 1 | Receive buffer read strobe |
| thr_wr_i | input | 1 | Transmit holding register write strobe |
| irq_o | output | 1 | Interrupt request |
| iid_o | output | 8 | Identification code |

## Verification
The bench builds the block with the default CNT_W of 5, which covers a full 16-entry count. Every trigger level can therefore be probed on both sides of its threshold, including 13 against 14. With all sources able to be pending together, the bench steps the priority ladder down one clear at a time. It also drives set and clear in the same cycle, and reads the identification register while a higher source hides the transmitter-empty source.

// File: rtl/uart_irq_pkg.sv
`timescale 1ns/1ps
package uart_irq_pkg;
  localparam int NSRC = 5;
  // priority index: 0 is highest
  localparam int P_LS   = 0;
  localparam int P_RDA  = 1;
  localparam int P_TO   = 2;
  localparam int P_THRE = 3;
  localparam int P_MS   = 4;

  typedef enum logic [2:0] {
    ID_MS   = 3'b000,
    ID_THRE = 3'b001,
    ID_RDA  = 3'b010,
    ID_LS   = 3'b011,
    ID_TO   = 3'b110
  } iid_e;

  function automatic iid_e src_code(input int idx);
    case (idx)
      P_LS:    return ID_LS;
      P_RDA:   return ID_RDA;
      P_TO:    return ID_TO;
      P_THRE:  return ID_THRE;
      default: return ID_MS;
    endcase
  endfunction

  function automatic logic [4:0] trig_level(input logic [1:0] sel);
    case (sel)
      2'b00:   return 5'd1;
      2'b01:   return 5'd4;
      2'b10:   return 5'd8;
      default: return 5'd14;
    endcase
  endfunction
endpackage

// File: rtl/irq_src_latch.sv
`timescale 1ns/1ps
module irq_src_latch #(
  parameter int EVT_W = 1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [EVT_W-1:0] evt_i,
  input  logic             clr_i,
  output logic             pend_o
);
  logic set;
  assign set = |evt_i;

  // a new event in the clearing cycle survives
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    pend_o <= 1'b0;
    else if (set)   pend_o <= 1'b1;
    else if (clr_i) pend_o <= 1'b0;
  end

  AST_SRC_SET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    set |=> pend_o); // R5
  AST_SRC_CLR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clr_i && !set) |=> !pend_o); // R9
endmodule

// File: rtl/irq_thre_src.sv
`timescale 1ns/1ps
module irq_thre_src (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic en_i,
  input  logic empty_i,
  input  logic thr_wr_i,
  input  logic iir_clr_i,
  output logic pend_o
);
  logic empty_q;
  logic rise;

  assign rise = empty_i && !empty_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) empty_q <= 1'b0;
    else         empty_q <= empty_i;
  end

  // clearing wins: a write means the FIFO is no longer empty
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                     pend_o <= 1'b0;
    else if (thr_wr_i || iir_clr_i)  pend_o <= 1'b0;
    else if (rise && en_i)           pend_o <= 1'b1;
  end

  AST_THRE_RISE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($rose(empty_i) && en_i && !thr_wr_i && !iir_clr_i) |=> pend_o); // R7
  AST_THRE_WR_CLR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    thr_wr_i |=> !pend_o); // R8
endmodule

// File: rtl/irq_rda_cmp.sv
`timescale 1ns/1ps
module irq_rda_cmp
  import uart_irq_pkg::*;
#(
  parameter int CNT_W = 5
) (
  input  logic [CNT_W-1:0] cnt_i,
  input  logic [1:0]       trig_sel_i,
  output logic             active_o
);
  logic [4:0] lvl;
  assign lvl      = trig_level(trig_sel_i);
  assign active_o = (int'(cnt_i) >= int'(lvl));
endmodule

// File: rtl/irq_prio_enc.sv
`timescale 1ns/1ps
module irq_prio_enc
  import uart_irq_pkg::*;
(
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic [NSRC-1:0] req_i,
  output logic [NSRC-1:0] grant_o,
  output logic [2:0]      code_o,
  output logic            any_o
);
  always_comb begin
    grant_o = '0;
    code_o  = ID_MS;
    for (int i = NSRC - 1; i >= 0; i--) begin
      if (req_i[i]) begin
        grant_o = '0;
        grant_o[i] = 1'b1;
        code_o  = src_code(i);
      end
    end
  end

  assign any_o = |req_i;

  AST_GRANT_ONEHOT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(grant_o)); // R3
  AST_LS_TOP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_i[P_LS] |-> (code_o == ID_LS)); // R3
endmodule

// File: rtl/uart_irq_id.sv
`timescale 1ns/1ps
module uart_irq_id
  import uart_irq_pkg::*;
#(
  parameter int CNT_W = 5
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [3:0]       en_i,
  input  logic [3:0]       line_err_i,
  input  logic [CNT_W-1:0] rx_cnt_i,
  input  logic [1:0]       trig_sel_i,
  input  logic             rx_timeout_i,
  input  logic             tx_empty_i,
  input  logic [3:0]       modem_delta_i,
  input  logic             iir_rd_i,
  input  logic             lsr_rd_i,
  input  logic             msr_rd_i,
  input  logic             rbr_rd_i,
  input  logic             thr_wr_i,
  output logic             irq_o,
  output logic [7:0]       iid_o
);
  logic ls_pend, to_pend, ms_pend, thre_pend, rda_act;
  logic [NSRC-1:0] raw, req, grant;
  logic [2:0] code;
  logic any;
  logic iir_thre_clr;

  irq_src_latch #(.EVT_W(4)) u_ls (
    .clk_i, .rst_ni, .evt_i(line_err_i), .clr_i(lsr_rd_i), .pend_o(ls_pend));

  irq_src_latch #(.EVT_W(1)) u_to (
    .clk_i, .rst_ni, .evt_i(rx_timeout_i), .clr_i(rbr_rd_i), .pend_o(to_pend));

  irq_src_latch #(.EVT_W(4)) u_ms (
    .clk_i, .rst_ni, .evt_i(modem_delta_i), .clr_i(msr_rd_i), .pend_o(ms_pend));

  irq_thre_src u_thre (
    .clk_i, .rst_ni, .en_i(en_i[1]), .empty_i(tx_empty_i),
    .thr_wr_i, .iir_clr_i(iir_thre_clr), .pend_o(thre_pend));

  irq_rda_cmp #(.CNT_W(CNT_W)) u_rda (
    .cnt_i(rx_cnt_i), .trig_sel_i, .active_o(rda_act));

  assign raw[P_LS]   = ls_pend;
  assign raw[P_RDA]  = rda_act;
  assign raw[P_TO]   = to_pend;
  assign raw[P_THRE] = thre_pend;
  assign raw[P_MS]   = ms_pend;

  // enable bit for each priority slot
  localparam int EN_IDX [NSRC] = '{2, 0, 0, 1, 3};

  for (genvar g = 0; g < NSRC; g++) begin : g_gate
    assign req[g] = raw[g] & en_i[EN_IDX[g]];
  end

  irq_prio_enc u_enc (
    .clk_i, .rst_ni, .req_i(req), .grant_o(grant), .code_o(code), .any_o(any));

  // code seen in the read cycle is the code returned by that read
  assign iir_thre_clr = iir_rd_i && grant[P_THRE];

  assign irq_o = any;
  assign iid_o = {2'b11, 2'b00, code, ~any};

  AST_IDLE_CODE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !irq_o |-> (iid_o == 8'hC1)); // R2
  AST_HIGH_BITS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    iid_o[7:4] == 4'hC); // R11
  AST_LS_CLEAR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (lsr_rd_i && line_err_i == 4'h0) |=> !ls_pend); // R5
  AST_TO_CLEAR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rbr_rd_i && !rx_timeout_i) |=> !to_pend); // R6
  AST_IIR_KEEP_THRE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (iir_rd_i && thre_pend && code != ID_THRE && !thr_wr_i) |=> thre_pend); // R8
endmodule

// File: tb/uart_irq_id_tb.sv
`timescale 1ns/1ps
module uart_irq_id_tb;
  localparam int CNT_W = 5;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic [3:0] en = '0, line_err = '0, mdelta = '0;
  logic [CNT_W-1:0] cnt = '0;
  logic [1:0] tsel = '0;
  logic tmo = 1'b0, txe = 1'b1;
  logic iir_rd = 1'b0, lsr_rd = 1'b0, msr_rd = 1'b0, rbr_rd = 1'b0, thr_wr = 1'b0;
  logic irq;
  logic [7:0] iid;

  int n_chk = 0, n_err = 0;

  always #2.5 clk = ~clk;

  uart_irq_id #(.CNT_W(CNT_W)) u_dut (
    .clk_i(clk), .rst_ni(rst_ni), .en_i(en), .line_err_i(line_err),
    .rx_cnt_i(cnt), .trig_sel_i(tsel), .rx_timeout_i(tmo), .tx_empty_i(txe),
    .modem_delta_i(mdelta), .iir_rd_i(iir_rd), .lsr_rd_i(lsr_rd),
    .msr_rd_i(msr_rd), .rbr_rd_i(rbr_rd), .thr_wr_i(thr_wr),
    .irq_o(irq), .iid_o(iid));

  localparam logic [7:0] C_NONE = 8'hC1, C_LS = 8'hC6, C_RDA = 8'hC4,
                         C_TO = 8'hCC, C_THRE = 8'hC2, C_MS = 8'hC0;

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s: actual %02h expected %02h", tag, act, exp);
    end
  endtask

  task automatic chk_out(input string tag, input logic [7:0] exp_iid);
    chk({tag, " iid"}, iid, exp_iid);
    chk({tag, " irq"}, {7'd0, irq}, {7'd0, ~exp_iid[0]});
  endtask

  // one clock edge, then settle away from the edge
  task automatic step();
    @(posedge clk);
    #1;
  endtask

  task automatic t_reset();
    chk_out("R1 reset", C_NONE);
    chk("R11 fixed bits", {iid[7:4], 4'h0}, 8'hC0);
  endtask

  task automatic t_rda();
    logic [4:0] lv [4] = '{5'd1, 5'd4, 5'd8, 5'd14};
    en = 4'b0001;
    for (int s = 0; s < 4; s++) begin
      tsel = 2'(s);
      cnt = CNT_W'(lv[s] - 1);
      #1 chk_out("R4 below trigger", C_NONE);
      cnt = CNT_W'(lv[s]);
      #1 chk_out("R4 at trigger", C_RDA);
      cnt = 5'd16;
      #1 chk_out("R4 above trigger", C_RDA);
    end
    cnt = 5'd13;
    #1 chk_out("R4 drops below 14", C_NONE);
    cnt = '0; tsel = '0; en = '0;
    #1;
  endtask

  task automatic t_ls();
    en = 4'b0101; cnt = 5'd1;
    #1 chk_out("R4 rda pending", C_RDA);
    line_err = 4'b0100; step(); line_err = '0;
    chk_out("R3 R5 ls over rda", C_LS);
    lsr_rd = 1'b1; line_err = 4'b0001; step(); lsr_rd = 1'b0; line_err = '0;
    chk_out("R5 set wins over read", C_LS);
    lsr_rd = 1'b1; step(); lsr_rd = 1'b0;
    chk_out("R5 cleared by read", C_RDA);
    cnt = '0;
    #1 chk_out("R2 nothing left", C_NONE);
  endtask

  task automatic t_timeout();
    en = 4'b0001;
    tmo = 1'b1; step(); tmo = 1'b0;
    chk_out("R6 timeout code", C_TO);
    cnt = 5'd1;
    #1 chk_out("R3 rda over timeout", C_RDA);
    cnt = '0;
    #1 chk_out("R6 timeout still", C_TO);
    rbr_rd = 1'b1; step(); rbr_rd = 1'b0;
    chk_out("R6 cleared by rbr read", C_NONE);
  endtask

  task automatic pulse_empty();
    txe = 1'b0; step(); txe = 1'b1; step();
  endtask

  task automatic t_thre();
    en = 4'b0010; step();
    chk_out("R7 no edge no source", C_NONE);
    pulse_empty();
    chk_out("R7 edge sets", C_THRE);
    thr_wr = 1'b1; step(); thr_wr = 1'b0;
    chk_out("R8 thr write clears", C_NONE);
    en = 4'b0000; pulse_empty(); en = 4'b0010;
    #1 chk_out("R7 edge while disabled", C_NONE);
    pulse_empty();
    iir_rd = 1'b1; step(); iir_rd = 1'b0;
    chk_out("R8 iir read clears", C_NONE);
    en = 4'b0110; pulse_empty();
    line_err = 4'b1000; step(); line_err = '0;
    chk_out("R3 ls over thre", C_LS);
    iir_rd = 1'b1; step(); iir_rd = 1'b0;
    chk_out("R8 iir read keeps hidden thre", C_LS);
    lsr_rd = 1'b1; step(); lsr_rd = 1'b0;
    chk_out("R8 thre exposed", C_THRE);
    thr_wr = 1'b1; step(); thr_wr = 1'b0;
    en = '0;
  endtask

  task automatic t_ms();
    en = 4'b1000;
    mdelta = 4'b0010; step(); mdelta = '0;
    chk_out("R9 modem code", C_MS);
    msr_rd = 1'b1; step(); msr_rd = 1'b0;
    chk_out("R9 msr read clears", C_NONE);
  endtask

  task automatic t_gate_ladder();
    en = 4'b0000;
    line_err = 4'b0010; mdelta = 4'b1000; tmo = 1'b1; step();
    line_err = '0; mdelta = '0; tmo = 1'b0;
    chk_out("R10 disabled sources silent", C_NONE);
    en = 4'b1000;
    #1 chk_out("R10 enabling modem reveals", C_MS);
    en = 4'b1111;
    #1 chk_out("R3 ladder top", C_LS);
    lsr_rd = 1'b1; step(); lsr_rd = 1'b0;
    chk_out("R3 ladder timeout", C_TO);
    rbr_rd = 1'b1; step(); rbr_rd = 1'b0;
    chk_out("R3 ladder modem", C_MS);
    msr_rd = 1'b1; step(); msr_rd = 1'b0;
    chk_out("R2 ladder empty", C_NONE);
    en = '0;
  endtask

  initial begin
    #1000000;
    n_err++;
    $display("FAIL watchdog: actual hung expected done");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_err);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 t_reset();
    @(negedge clk) rst_ni = 1'b1;
    step();
    t_reset();
    t_rda();
    t_ls();
    t_timeout();
    t_thre();
    t_ms();
    t_gate_ladder();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_err);
    $finish;
  end
endmodule